// File: doc/BRIEF.md
# User-Level Interrupt Domain Switcher

This block takes a user-level interrupt straight into the protection domain that owns it, with no kernel code on the path. It does so whether or not that domain is the one currently scheduled. When a request and its interrupt number are accepted, the block first resolves the owning domain through a per-interrupt owner map. It then copies that domain's memory-protection regions into the live user protection registers, one region per cycle, and loads the domain's cycle budget into a down-counting timer. Next it takes care of the interrupted register context. In the stacking variant it writes the context out word by word through a handshaked write port. In the banked variant it switches a register bank select instead. Finally it raises a one-cycle vector-fetch strobe that carries the target domain.

The kernel keeps its own set of protection registers in a separate shadow bank. A switch never touches that bank. The owner map, the region table, the budget table and the kernel bank are written through a simple table-write port. When the context port does not stall, each variant has a fixed latency that follows from its parameters. A request that arrives during a switch goes into a one-entry holding slot and is served after the current switch ends.

Top module: `uli_switcher`

## Requirements
- R1: After reset: irq_ready is 1; busy, vector_fetch, stk_valid, overrun and budget_expired are 0; region_regs and budget_count are 0.
- R2: In the stacking variant (BANKED=0) with stk_ready held high, vector_fetch rises exactly REGIONS+STACK_REGS+2 clock edges after the edge that accepts the request. With the defaults this is 26 edges.
- R3: In the banked variant (BANKED=1), vector_fetch rises exactly REGIONS+2 edges after the accepting edge (10 with the defaults). stk_valid never rises, and ctx_bank equals the target domain when the vector is fetched.
- R4: vector_domain equals the owner-map entry for the accepted interrupt number. While vector_fetch is high, region_regs holds that domain's region-table entries, with region i in bits [i*REGION_W +: REGION_W].
- R5: A switch never changes kern_regions. Only a table write with cfg_sel=3 changes that bank.
- R6: The budget timer is loaded one cycle after the last region copy and then counts down by one per cycle. At the vector fetch it reads budget-STACK_REGS in the stacking variant and budget-1 in the banked variant. budget_expired pulses for exactly one cycle in the cycle the count first reads 0. A budget of 0 produces no pulse.
- R7: The stacking variant writes register words 0 to STACK_REGS-1 in ascending order. stk_index gives the word number and stk_data gives bits [i*DATA_W +: DATA_W] of ctx_regs. A word stays presented until stk_ready accepts it.
- R8: Each cycle in which stk_valid is high and stk_ready is low adds one cycle to the latency. Such a cycle also sets overrun, which stays set until reset.
- R9: A request accepted while a switch is in progress goes into a one-entry holding slot, and irq_ready stays low while the slot is full. The current switch still completes with its own domain, and the held request starts on the second edge after the vector fetch.
- R10: vector_fetch is high for exactly one cycle. On the next edge the block returns to idle and busy falls.
- R11: Table writes use cfg_sel to pick the table: 0 is the owner map (cfg_addr = interrupt number, cfg_wdata = domain), 1 is a region (cfg_dom, cfg_addr = region index), 2 is a budget (cfg_dom), and 3 is a kernel region (cfg_addr = region index).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Interrupt request present |
| irq_id | input | ID_W | Interrupt number of the request |
| irq_ready | output | 1 | Request can be accepted (holding slot empty) |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select (see R11) |
| cfg_dom | input | DOM_W | Domain for region and budget writes |
| cfg_addr | input | ID_W | Interrupt number or region index |
| cfg_wdata | input | CFG_W | Write data |
| ctx_regs | input | STACK_REGS*DATA_W | Interrupted register context |
| stk_valid | output | 1 | Context word presented |
| stk_index | output | SIDX_W | Context word number |
| stk_data | output | DATA_W | Context word value |
| stk_ready | input | 1 | Context store accepts word |
| region_regs | output | REGIONS*REGION_W | Live user protection regions |
| kern_regions | output | REGIONS*REGION_W | Kernel shadow protection regions |
| budget_count | output | BUDGET_W | Budget timer value |
| budget_expired | output | 1 | One-cycle pulse when budget runs out |
| ctx_bank | output | DOM_W | Selected register bank (banked variant) |
| overrun | output | 1 | Sticky: context port stalled |
| busy | output | 1 | Switch in progress |
| vector_fetch | output | 1 | One-cycle vector fetch strobe |
| vector_domain | output | DOM_W | Domain the vector fetch runs in |

## Verification
The bench counts clock edges from acceptance to the vector strobe in both variants. An extra or missing state in the sequence would move the strobe off 26 or 10. It injects a three-cycle stall on the context port to check that the word under stall is held rather than skipped, that the latency grows by exactly three, and that the overrun flag latches. A second request is issued in the middle of a switch to catch a design that aborts the first switch or drops the held one. Budgets of 5 and 0 probe the expiry pulse: an off-by-one decrement would move the pulse, and a missing zero guard would raise a pulse on an empty budget.

// File: rtl/uli_pkg.sv
package uli_pkg;

   // Sequencer states of the domain switcher
   typedef enum logic [2:0] {
      SW_IDLE,
      SW_LOOKUP,
      SW_PROT,
      SW_BUDGET,
      SW_CTX,
      SW_VEC
   } sw_state_e;

   // Table selector codes on the table-write port
   typedef enum logic [1:0] {
      CFG_OWNER  = 2'd0,
      CFG_REGION = 2'd1,
      CFG_BUDGET = 2'd2,
      CFG_KERNEL = 2'd3
   } cfg_sel_e;

endpackage

// File: rtl/uli_tables.sv
module uli_tables
   import uli_pkg::*;
#(
   parameter int NUM_IRQ     = 16,
   parameter int NUM_DOMAINS = 8,
   parameter int REGIONS     = 8,
   parameter int REGION_W    = 32,
   parameter int BUDGET_W    = 32,
   parameter int CFG_W       = 32,
   localparam int ID_W   = $clog2(NUM_IRQ),
   localparam int DOM_W  = $clog2(NUM_DOMAINS),
   localparam int RIDX_W = $clog2(REGIONS),
   localparam int RT_AW  = DOM_W + RIDX_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [1:0]                  cfg_sel,
   input  logic [DOM_W-1:0]            cfg_dom,
   input  logic [ID_W-1:0]             cfg_addr,
   input  logic [CFG_W-1:0]            cfg_wdata,
   input  logic [ID_W-1:0]             own_irq,
   output logic [DOM_W-1:0]            own_dom,
   input  logic [DOM_W-1:0]            rd_dom,
   input  logic [RIDX_W-1:0]           rd_idx,
   output logic [REGION_W-1:0]         rd_region,
   output logic [BUDGET_W-1:0]         rd_budget,
   output logic [REGIONS*REGION_W-1:0] kern_flat
);

   logic [DOM_W-1:0]    owner_q  [NUM_IRQ];
   logic [REGION_W-1:0] region_q [NUM_DOMAINS*REGIONS];
   logic [BUDGET_W-1:0] budget_q [NUM_DOMAINS];
   logic [REGION_W-1:0] kern_q   [REGIONS];

   logic [RT_AW-1:0]  wr_slot;
   logic [RIDX_W-1:0] wr_ridx;

   assign wr_ridx = cfg_addr[RIDX_W-1:0];
   assign wr_slot = {cfg_dom, wr_ridx};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_IRQ; i++)               owner_q[i]  <= '0;
         for (int i = 0; i < NUM_DOMAINS*REGIONS; i++)   region_q[i] <= '0;
         for (int i = 0; i < NUM_DOMAINS; i++)           budget_q[i] <= '0;
         for (int i = 0; i < REGIONS; i++)               kern_q[i]   <= '0;
      end else if (cfg_we) begin
         unique case (cfg_sel)
            CFG_OWNER:  owner_q[cfg_addr]  <= cfg_wdata[DOM_W-1:0];
            CFG_REGION: region_q[wr_slot]  <= cfg_wdata[REGION_W-1:0];
            CFG_BUDGET: budget_q[cfg_dom]  <= cfg_wdata[BUDGET_W-1:0];
            default:    kern_q[wr_ridx]    <= cfg_wdata[REGION_W-1:0];
         endcase
      end
   end

   assign own_dom   = owner_q[own_irq];
   assign rd_region = region_q[{rd_dom, rd_idx}];
   assign rd_budget = budget_q[rd_dom];

   for (genvar g = 0; g < REGIONS; g++) begin : g_kern
      assign kern_flat[g*REGION_W +: REGION_W] = kern_q[g];
   end

endmodule

// File: rtl/uli_budget_timer.sv
module uli_budget_timer #(
   parameter int BUDGET_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [BUDGET_W-1:0] load_val,
   output logic [BUDGET_W-1:0] count,
   output logic                expired
);

   localparam logic [BUDGET_W-1:0] ONE = BUDGET_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count   <= '0;
         expired <= 1'b0;
      end else begin
         expired <= 1'b0;
         if (load) begin
            count <= load_val;
         end else if (count != '0) begin
            count <= count - ONE;
            if (count == ONE) expired <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/uli_ctx_unit.sv
module uli_ctx_unit #(
   parameter int STACK_REGS = 16,
   parameter int DATA_W     = 32,
   parameter int DOM_W      = 3,
   parameter bit BANKED     = 1'b0,
   localparam int SIDX_W    = $clog2(STACK_REGS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         go,
   input  logic [DOM_W-1:0]             dom,
   input  logic [STACK_REGS*DATA_W-1:0] ctx_regs,
   input  logic                         stk_ready,
   output logic                         stk_valid,
   output logic [SIDX_W-1:0]            stk_index,
   output logic [DATA_W-1:0]            stk_data,
   output logic [DOM_W-1:0]             bank,
   output logic                         done,
   output logic                         overrun
);

   if (BANKED) begin : g_bank
      // One-cycle register bank switch replaces the context save
      logic [DOM_W-1:0] bank_q;
      logic             unused_stack;

      always_ff @(posedge clk) begin
         if (!rst_n)  bank_q <= '0;
         else if (go) bank_q <= dom;
      end

      assign unused_stack = stk_ready ^ (^ctx_regs);
      assign bank      = bank_q;
      assign done      = go;
      assign stk_valid = 1'b0;
      assign stk_index = '0;
      assign stk_data  = '0;
      assign overrun   = 1'b0;
   end else begin : g_stack
      // Word-per-cycle save through a valid/ready write port
      localparam logic [SIDX_W-1:0] LAST = SIDX_W'(STACK_REGS-1);
      logic [SIDX_W-1:0] idx_q;
      logic              ovr_q;
      logic              unused_dom;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            idx_q <= '0;
            ovr_q <= 1'b0;
         end else begin
            if (!go)            idx_q <= '0;
            else if (stk_ready) idx_q <= idx_q + SIDX_W'(1);
            if (go && !stk_ready) ovr_q <= 1'b1;
         end
      end

      assign unused_dom = ^dom;
      assign bank      = '0;
      assign stk_valid = go;
      assign stk_index = idx_q;
      assign stk_data  = ctx_regs[idx_q*DATA_W +: DATA_W];
      assign done      = go && stk_ready && (idx_q == LAST);
      assign overrun   = ovr_q;
   end

endmodule

// File: rtl/uli_switcher.sv
module uli_switcher
   import uli_pkg::*;
#(
   parameter int NUM_IRQ     = 16,
   parameter int NUM_DOMAINS = 8,
   parameter int REGIONS     = 8,
   parameter int REGION_W    = 32,
   parameter int BUDGET_W    = 32,
   parameter int STACK_REGS  = 16,
   parameter int DATA_W      = 32,
   parameter bit BANKED      = 1'b0,
   localparam int ID_W   = $clog2(NUM_IRQ),
   localparam int DOM_W  = $clog2(NUM_DOMAINS),
   localparam int RIDX_W = $clog2(REGIONS),
   localparam int SIDX_W = $clog2(STACK_REGS),
   localparam int CFG_W  = (REGION_W > BUDGET_W) ? REGION_W : BUDGET_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         irq_valid,
   input  logic [ID_W-1:0]              irq_id,
   output logic                         irq_ready,
   input  logic                         cfg_we,
   input  logic [1:0]                   cfg_sel,
   input  logic [DOM_W-1:0]             cfg_dom,
   input  logic [ID_W-1:0]              cfg_addr,
   input  logic [CFG_W-1:0]             cfg_wdata,
   input  logic [STACK_REGS*DATA_W-1:0] ctx_regs,
   output logic                         stk_valid,
   output logic [SIDX_W-1:0]            stk_index,
   output logic [DATA_W-1:0]            stk_data,
   input  logic                         stk_ready,
   output logic [REGIONS*REGION_W-1:0]  region_regs,
   output logic [REGIONS*REGION_W-1:0]  kern_regions,
   output logic [BUDGET_W-1:0]          budget_count,
   output logic                         budget_expired,
   output logic [DOM_W-1:0]             ctx_bank,
   output logic                         overrun,
   output logic                         busy,
   output logic                         vector_fetch,
   output logic [DOM_W-1:0]             vector_domain
);

   // Elaboration-time parameter checks
   if (NUM_IRQ < 2)                                        begin : g_chk_irq
      $error("uli_switcher: NUM_IRQ must be at least 2");
   end
   if (NUM_DOMAINS < 2 || (1 << DOM_W) != NUM_DOMAINS)     begin : g_chk_dom
      $error("uli_switcher: NUM_DOMAINS must be a power of two >= 2");
   end
   if (REGIONS < 2 || (1 << RIDX_W) != REGIONS)            begin : g_chk_reg
      $error("uli_switcher: REGIONS must be a power of two >= 2");
   end
   if (RIDX_W > ID_W)                                      begin : g_chk_addr
      $error("uli_switcher: cfg_addr too narrow for region index");
   end
   if (STACK_REGS < 2)                                     begin : g_chk_stk
      $error("uli_switcher: STACK_REGS must be at least 2");
   end

   localparam logic [RIDX_W-1:0] RIDX_LAST = RIDX_W'(REGIONS-1);
   localparam bit DIRECT = BANKED;

   sw_state_e           state_q;
   logic [DOM_W-1:0]    dom_q;
   logic [ID_W-1:0]     id_q;
   logic [RIDX_W-1:0]   ridx_q;
   logic                pend_q;
   logic [ID_W-1:0]     pend_id_q;
   logic [REGION_W-1:0] act_q [REGIONS];

   logic                start;
   logic [ID_W-1:0]     start_id;
   logic [ID_W-1:0]     lookup_id;
   logic [DOM_W-1:0]    owner_dom;
   logic [REGION_W-1:0] region_rd;
   logic [BUDGET_W-1:0] budget_rd;
   logic                ctx_done;

   assign irq_ready = !pend_q;
   assign start_id  = pend_q ? pend_id_q : irq_id;
   assign start     = (state_q == SW_IDLE) && (pend_q || irq_valid);

   // Owner lookup: merged into the accept cycle or given its own stage
   if (BANKED) begin : g_direct
      assign lookup_id = start_id;
   end else begin : g_staged
      assign lookup_id = id_q;
   end

   uli_tables #(
      .NUM_IRQ     (NUM_IRQ),
      .NUM_DOMAINS (NUM_DOMAINS),
      .REGIONS     (REGIONS),
      .REGION_W    (REGION_W),
      .BUDGET_W    (BUDGET_W),
      .CFG_W       (CFG_W)
   ) tables_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_dom   (cfg_dom),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .own_irq   (lookup_id),
      .own_dom   (owner_dom),
      .rd_dom    (dom_q),
      .rd_idx    (ridx_q),
      .rd_region (region_rd),
      .rd_budget (budget_rd),
      .kern_flat (kern_regions)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SW_IDLE;
         dom_q     <= '0;
         id_q      <= '0;
         ridx_q    <= '0;
         pend_q    <= 1'b0;
         pend_id_q <= '0;
         for (int i = 0; i < REGIONS; i++) act_q[i] <= '0;
      end else begin
         if (irq_valid && irq_ready && state_q != SW_IDLE) begin
            pend_q    <= 1'b1;
            pend_id_q <= irq_id;
         end
         unique case (state_q)
            SW_IDLE: begin
               if (start) begin
                  pend_q <= 1'b0;
                  ridx_q <= '0;
                  if (DIRECT) begin
                     dom_q   <= owner_dom;
                     state_q <= SW_PROT;
                  end else begin
                     id_q    <= start_id;
                     state_q <= SW_LOOKUP;
                  end
               end
            end
            SW_LOOKUP: begin
               dom_q   <= owner_dom;
               ridx_q  <= '0;
               state_q <= SW_PROT;
            end
            SW_PROT: begin
               act_q[ridx_q] <= region_rd;
               ridx_q        <= ridx_q + RIDX_W'(1);
               if (ridx_q == RIDX_LAST) state_q <= SW_BUDGET;
            end
            SW_BUDGET: state_q <= SW_CTX;
            SW_CTX:    if (ctx_done) state_q <= SW_VEC;
            SW_VEC:    state_q <= SW_IDLE;
            default:   state_q <= SW_IDLE;
         endcase
      end
   end

   uli_budget_timer #(
      .BUDGET_W (BUDGET_W)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_q == SW_BUDGET),
      .load_val (budget_rd),
      .count    (budget_count),
      .expired  (budget_expired)
   );

   uli_ctx_unit #(
      .STACK_REGS (STACK_REGS),
      .DATA_W     (DATA_W),
      .DOM_W      (DOM_W),
      .BANKED     (BANKED)
   ) ctx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (state_q == SW_CTX),
      .dom       (dom_q),
      .ctx_regs  (ctx_regs),
      .stk_ready (stk_ready),
      .stk_valid (stk_valid),
      .stk_index (stk_index),
      .stk_data  (stk_data),
      .bank      (ctx_bank),
      .done      (ctx_done),
      .overrun   (overrun)
   );

   for (genvar g = 0; g < REGIONS; g++) begin : g_act
      assign region_regs[g*REGION_W +: REGION_W] = act_q[g];
   end

   assign busy          = (state_q != SW_IDLE);
   assign vector_fetch  = (state_q == SW_VEC);
   assign vector_domain = dom_q;

endmodule

// File: rtl/uli_switcher_chk.sv
module uli_switcher_chk
   import uli_pkg::*;
#(
   parameter int REGIONS    = 8,
   parameter int REGION_W   = 32,
   parameter int BUDGET_W   = 32,
   parameter int STACK_REGS = 16,
   localparam int SIDX_W    = $clog2(STACK_REGS)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_we,
   input logic [1:0]                  cfg_sel,
   input logic                        stk_valid,
   input logic                        stk_ready,
   input logic [SIDX_W-1:0]           stk_index,
   input logic                        overrun,
   input logic                        busy,
   input logic                        vector_fetch,
   input logic                        budget_expired,
   input logic [BUDGET_W-1:0]         budget_count,
   input logic [REGIONS*REGION_W-1:0] kern_regions
);

   // R10
   vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vector_fetch |=> !vector_fetch);

   // R10
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vector_fetch |=> !busy);

   // R8
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R8
   stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_valid && !stk_ready) |=> overrun);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_index)));

   // R6
   expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      budget_expired |-> (budget_count == '0));

   // R5
   kern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_sel == CFG_KERNEL) |=> $stable(kern_regions));

endmodule

bind uli_switcher uli_switcher_chk #(
   .REGIONS    (REGIONS),
   .REGION_W   (REGION_W),
   .BUDGET_W   (BUDGET_W),
   .STACK_REGS (STACK_REGS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_we         (cfg_we),
   .cfg_sel        (cfg_sel),
   .stk_valid      (stk_valid),
   .stk_ready      (stk_ready),
   .stk_index      (stk_index),
   .overrun        (overrun),
   .busy           (busy),
   .vector_fetch   (vector_fetch),
   .budget_expired (budget_expired),
   .budget_count   (budget_count),
   .kern_regions   (kern_regions)
);

// File: tb/uli_switcher_tb_top.sv
module uli_switcher_tb_top;

   localparam int NR = 8;
   localparam int NS = 16;
   localparam int STK_LAT = NR + NS + 2;
   localparam int BNK_LAT = NR + 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n;
   logic         cfg_we;
   logic [1:0]   cfg_sel;
   logic [2:0]   cfg_dom;
   logic [3:0]   cfg_addr;
   logic [31:0]  cfg_wdata;
   logic [511:0] ctx_regs;

   logic irq_valid_s, irq_ready_s, stk_valid_s, stk_ready_s, bexp_s, ovr_s, busy_s, vf_s;
   logic [3:0] irq_id_s, sidx_s;
   logic [31:0] sdata_s, bcount_s;
   logic [255:0] region_s, kern_s;
   logic [2:0] bank_s, vdom_s;

   logic irq_valid_b, irq_ready_b, stk_valid_b, stk_ready_b, bexp_b, ovr_b, busy_b, vf_b;
   logic [3:0] irq_id_b, sidx_b;
   logic [31:0] sdata_b, bcount_b;
   logic [255:0] region_b, kern_b;
   logic [2:0] bank_b, vdom_b;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   uli_switcher dut_i (
      .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid_s), .irq_id(irq_id_s), .irq_ready(irq_ready_s),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_dom(cfg_dom), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .ctx_regs(ctx_regs), .stk_valid(stk_valid_s), .stk_index(sidx_s), .stk_data(sdata_s),
      .stk_ready(stk_ready_s), .region_regs(region_s), .kern_regions(kern_s), .budget_count(bcount_s),
      .budget_expired(bexp_s), .ctx_bank(bank_s), .overrun(ovr_s), .busy(busy_s),
      .vector_fetch(vf_s), .vector_domain(vdom_s)
   );

   uli_switcher #(.BANKED(1'b1)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid_b), .irq_id(irq_id_b), .irq_ready(irq_ready_b),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_dom(cfg_dom), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .ctx_regs(ctx_regs), .stk_valid(stk_valid_b), .stk_index(sidx_b), .stk_data(sdata_b),
      .stk_ready(stk_ready_b), .region_regs(region_b), .kern_regions(kern_b), .budget_count(bcount_b),
      .budget_expired(bexp_b), .ctx_bank(bank_b), .overrun(ovr_b), .busy(busy_b),
      .vector_fetch(vf_b), .vector_domain(vdom_b)
   );

   function automatic logic [2:0] own_of(int id);
      return 3'((id * 5 + 3) % 8);
   endfunction

   function automatic logic [31:0] reg_val(int d, int i);
      return 32'hA000_0000 | 32'(d << 8) | 32'(i);
   endfunction

   function automatic logic [31:0] ctx_val(int w);
      return 32'hC0DE_0000 + 32'(w);
   endfunction

   function automatic logic [31:0] bud(int d);
      return 32'(100 + 7 * d);
   endfunction

   function automatic logic [255:0] exp_regions(int d);
      logic [255:0] v;
      for (int i = 0; i < NR; i++) v[i*32 +: 32] = reg_val(d, i);
      return v;
   endfunction

   function automatic logic [255:0] exp_kern();
      logic [255:0] v;
      for (int i = 0; i < NR; i++) v[i*32 +: 32] = 32'hBEEF_0000 + 32'(i);
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic cfg_write(input logic [1:0] sel, input int dom, input int addr, input logic [31:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_dom = 3'(dom); cfg_addr = 4'(addr); cfg_wdata = data;
      step();
      cfg_we = 1'b0;
   endtask

   // Stacking-variant switch; optional stall window on the context port
   task automatic run_stack(input int id, input int stall_at, input int stall_len,
                            output int lat, output int words, output bit word_ok);
      int n;
      irq_id_s = 4'(id); irq_valid_s = 1'b1;
      step();
      irq_valid_s = 1'b0;
      n = 0; words = 0; word_ok = 1'b1;
      while (!vf_s && n < 200) begin
         stk_ready_s = !(n >= stall_at && n < stall_at + stall_len);
         if (stk_valid_s && stk_ready_s) begin
            if (sidx_s != 4'(words) || sdata_s != ctx_val(words)) word_ok = 1'b0;
            words++;
         end
         step();
         n++;
      end
      stk_ready_s = 1'b1;
      lat = n;
   endtask

   task automatic run_banked(input int id, output int lat, output bit saw_stk);
      int n;
      irq_id_b = 4'(id); irq_valid_b = 1'b1;
      step();
      irq_valid_b = 1'b0;
      n = 0; saw_stk = 1'b0;
      while (!vf_b && n < 200) begin
         if (stk_valid_b) saw_stk = 1'b1;
         step();
         n++;
      end
      lat = n;
   endtask

   task automatic t_reset();
      chk(irq_ready_s && irq_ready_b, "R1", "irq_ready", {irq_ready_s, irq_ready_b}, 2'b11);
      chk(!busy_s && !vf_s && !stk_valid_s && !ovr_s && !bexp_s, "R1", "stacking flags",
          {busy_s, vf_s, stk_valid_s, ovr_s, bexp_s}, 0);
      chk(!busy_b && !vf_b && !bexp_b, "R1", "banked flags", {busy_b, vf_b, bexp_b}, 0);
      chk(region_s == '0 && bcount_s == '0, "R1", "regions/budget", region_s | bcount_s, 0);
   endtask

   task automatic t_configure();
      for (int id = 0; id < 16; id++) cfg_write(2'd0, 0, id, 32'(own_of(id)));
      for (int d = 0; d < 8; d++) begin
         for (int i = 0; i < NR; i++) cfg_write(2'd1, d, i, reg_val(d, i));
         cfg_write(2'd2, d, 0, bud(d));
      end
      for (int i = 0; i < NR; i++) cfg_write(2'd3, 0, i, 32'hBEEF_0000 + 32'(i));
      chk(kern_s == exp_kern(), "R11", "kernel bank after writes", kern_s, exp_kern());
      chk(region_s == '0, "R11", "table writes leave live regions", region_s, 0);
   endtask

   task automatic t_stack_switch(input int id);
      int lat, words; bit ok; logic [2:0] d;
      d = own_of(id);
      run_stack(id, 999, 0, lat, words, ok);
      chk(lat == STK_LAT, "R2", "stacking latency", lat, STK_LAT);
      chk(ok && words == NS, "R7", "stacked words", words, NS);
      chk(vdom_s == d, "R4", "vector domain", vdom_s, d);
      chk(region_s == exp_regions(d), "R4", "live regions", region_s, exp_regions(d));
      chk(bcount_s == bud(d) - 32'(NS), "R6", "timer at vector", bcount_s, bud(d) - 32'(NS));
      chk(kern_s == exp_kern(), "R5", "kernel bank untouched", kern_s, exp_kern());
      step();
      chk(!vf_s && !busy_s, "R10", "one-cycle strobe then idle", {vf_s, busy_s}, 0);
   endtask

   task automatic t_banked_switch(input int id);
      int lat; bit saw; logic [2:0] d;
      d = own_of(id);
      run_banked(id, lat, saw);
      chk(lat == BNK_LAT, "R3", "banked latency", lat, BNK_LAT);
      chk(!saw, "R3", "no stack writes", saw, 0);
      chk(bank_b == d, "R3", "bank select", bank_b, d);
      chk(vdom_b == d && region_b == exp_regions(d), "R4", "banked domain/regions", region_b, exp_regions(d));
      chk(bcount_b == bud(d) - 32'd1, "R6", "banked timer at vector", bcount_b, bud(d) - 32'd1);
      chk(kern_b == exp_kern(), "R5", "banked kernel bank untouched", kern_b, exp_kern());
      step();
      chk(!vf_b && !busy_b, "R10", "banked strobe then idle", {vf_b, busy_b}, 0);
   endtask

   task automatic t_expire();
      int lat, first, cnt; bit saw;
      cfg_write(2'd2, own_of(7), 0, 32'd5);
      run_banked(7, lat, saw);
      first = -1; cnt = 0;
      for (int k = 1; k <= 8; k++) begin
         step();
         if (bexp_b) begin
            cnt++;
            if (first < 0) first = k;
         end
      end
      chk(first == 4 && cnt == 1, "R6", "expiry pulse edge", first, 4);
      chk(bcount_b == '0, "R6", "timer rests at zero", bcount_b, 0);
   endtask

   task automatic t_zero_budget();
      int lat, cnt; bit saw;
      cfg_write(2'd2, own_of(9), 0, 32'd0);
      run_banked(9, lat, saw);
      cnt = 0;
      for (int k = 0; k < 20; k++) begin
         if (bexp_b) cnt++;
         step();
      end
      chk(cnt == 0 && bcount_b == '0, "R6", "zero budget gives no pulse", cnt, 0);
   endtask

   task automatic t_pending();
      int n, first, second; logic [2:0] da, db; bit ready_low, ready_back;
      irq_id_s = 4'd3; irq_valid_s = 1'b1;
      step();
      irq_valid_s = 1'b0;
      n = 0; first = -1; second = -1; da = '0; db = '0; ready_low = 1'b0; ready_back = 1'b0;
      while (n < 80) begin
         if (vf_s) begin
            if (first < 0) begin first = n; da = vdom_s; end
            else begin second = n; db = vdom_s; end
         end
         if (n == 3) begin irq_id_s = 4'd10; irq_valid_s = 1'b1; end
         if (n == 4) begin irq_valid_s = 1'b0; ready_low = !irq_ready_s; end
         if (n == 30) ready_back = irq_ready_s;
         step();
         n++;
      end
      chk(ready_low, "R9", "slot full drops irq_ready", irq_ready_s, 0);
      chk(first == STK_LAT && da == own_of(3), "R9", "first switch not aborted", first, STK_LAT);
      chk(second == 2*STK_LAT + 2 && db == own_of(10), "R9", "held request served", second, 2*STK_LAT + 2);
      chk(ready_back, "R9", "slot released", ready_back, 1);
   endtask

   task automatic t_stall();
      int lat, words; bit ok;
      chk(!ovr_s, "R8", "no overrun without stall", ovr_s, 0);
      run_stack(5, 12, 3, lat, words, ok);
      chk(lat == STK_LAT + 3, "R8", "stall lengthens latency", lat, STK_LAT + 3);
      chk(ok && words == NS, "R7", "words under stall", words, NS);
      chk(vdom_s == own_of(5), "R4", "domain after stall", vdom_s, own_of(5));
      step();
      chk(ovr_s, "R8", "overrun sticky", ovr_s, 1);
   endtask

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_dom = '0; cfg_addr = '0; cfg_wdata = '0;
      irq_valid_s = 1'b0; irq_id_s = '0; stk_ready_s = 1'b1;
      irq_valid_b = 1'b0; irq_id_b = '0; stk_ready_b = 1'b1;
      for (int w = 0; w < NS; w++) ctx_regs[w*32 +: 32] = ctx_val(w);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_configure();
      t_stack_switch(2);
      t_stack_switch(13);
      t_banked_switch(6);
      t_expire();
      t_zero_budget();
      t_pending();
      t_stall();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule